// File: doc/BRIEF.md
# Periodic Interrupt Rate Divider

This block turns a time-base clock enable into a periodic tick whose rate is set by a 4-bit rate code. A 3-bit divisor code names the time base. For the two fast bases a prescaler first brings the enable down to a common reference rate (32768 Hz in the nominal setting). For the slow 32 kHz base the enable is used directly. A binary divider chain then counts reference pulses, and the rate code picks how many low chain bits must all be ones before a tick fires. Each tick is one clock cycle wide and is meant to set a periodic flag elsewhere. Clearing that flag and combining interrupts are not part of this block.

A square-wave level toggles on every tick, so its frequency is half the tick rate. The level reaches its output only while the square-wave enable is high. Whenever the rate or divisor code changes, the prescaler and the divider chain restart from zero, and no stray tick is produced during the change. Two divisor codes hold the chain in reset. The three remaining undefined codes freeze the time base.

All control inputs are plain levels. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `periodic_rate_div`

## Requirements
- R1: While `rst_n` is low, `tick` and `sqw_out` are 0.
- R2: With `tb_en` held high, rate code n in 3..15 gives one tick every ratio × 2^(n-1) clock cycles. The ratio comes from `div_sel`: 3'b000 gives PRE_FAST (default 128), 3'b001 gives PRE_MID (default 32), and 3'b010 gives 1.
- R3: Rate codes 1 and 2 depend on the base. With `div_sel` = 3'b010 they give 2^7 and 2^8 reference pulses per tick. With 3'b000 or 3'b001 they give 1 and 2 reference pulses per tick.
- R4: Rate code 0 produces no tick and forces the square-wave level to 0.
- R5: `div_sel` 3'b110 or 3'b111 holds the prescaler and the chain at zero, produces no tick, and forces the square-wave level to 0.
- R6: `div_sel` 3'b011, 3'b100 or 3'b101 freezes the time base. No tick occurs and the square-wave level keeps its value.
- R7: The prescaler and the chain advance only in cycles where `tb_en` is high. If `tb_en` is low in a cycle, `tick` is 0 in the following cycle.
- R8: When {`div_sel`,`rate_sel`} differs from its value at the previous clock edge, that edge clears the prescaler and the chain and does not raise `tick`. The first new tick is then high exactly one full period after that edge.
- R9: The square-wave level toggles at the edge that raises `tick`. `sqw_out` equals that level while `sqw_en` is 1, and is 0 while `sqw_en` is 0.
- R10: `tick` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_en | input | 1 | Time-base enable, one pulse per time-base period |
| rate_sel | input | 4 | Periodic rate code (0 = off) |
| div_sel | input | 3 | Divisor code: 000 fast, 001 mid, 010 32 kHz, 011..101 freeze, 11x hold in reset |
| sqw_en | input | 1 | Square-wave output enable |
| tick | output | 1 | One-cycle periodic tick |
| sqw_out | output | 1 | Square-wave output level |

## Verification
The hardest case to reach is the slowest setting, rate 15 on the slow base, where a single period is 16384 cycles. A close second is proving that a code change made part-way through a period neither leaks a stale tick nor shortens the next one. The driver writes a new code just after a tick has been observed. At that moment the prescaler and the chain hold nonzero partial counts, so a missing clear would show up as an early first tick. The scoreboard expects the first tick exactly one full period after the edge that samples the change. Stopping `tb_en` mid-period and then restarting through a code change exercises the same path with a stalled chain.

// File: rtl/prd_pkg.sv
package prd_pkg;

  typedef enum logic [1:0] {
    BASE_RUN    = 2'd0,
    BASE_FREEZE = 2'd1,
    BASE_HOLD   = 2'd2
  } base_mode_e;

  localparam logic [2:0] DIV_FAST = 3'b000;
  localparam logic [2:0] DIV_MID  = 3'b001;
  localparam logic [2:0] DIV_SLOW = 3'b010;

  // Classify a divisor code into run / freeze / hold-in-reset.
  function automatic base_mode_e base_mode(input logic [2:0] d);
    base_mode_e m;
    if (d[2:1] == 2'b11)
      m = BASE_HOLD;
    else if (d == DIV_FAST || d == DIV_MID || d == DIV_SLOW)
      m = BASE_RUN;
    else
      m = BASE_FREEZE;
    return m;
  endfunction

  // Number of low chain bits that must be all ones for a tick.
  function automatic logic [3:0] tap_exp(input logic [3:0] r, input logic slow);
    logic [3:0] e;
    case (r)
      4'd1:    e = slow ? 4'd7 : 4'd0;
      4'd2:    e = slow ? 4'd8 : 4'd1;
      default: e = r - 4'd1;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/prd_prescaler.sv
module prd_prescaler #(
  parameter int PRE_FAST = 128,
  parameter int PRE_MID  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       run,
  input  logic       tb_en,
  input  logic [2:0] div_sel,
  output logic       ref_pulse
);
  import prd_pkg::*;

  localparam int PRE_MAX = (PRE_FAST > PRE_MID) ? PRE_FAST : PRE_MID;
  localparam int PW      = (PRE_MAX > 2) ? $clog2(PRE_MAX) : 1;

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] lim;

  always_comb begin
    case (div_sel)
      DIV_FAST: lim = PW'(PRE_FAST - 1);
      DIV_MID:  lim = PW'(PRE_MID - 1);
      default:  lim = '0;
    endcase
  end

  assign ref_pulse = run && tb_en && (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      cnt_q <= '0;
    else if (run && tb_en)
      cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
  end

endmodule

// File: rtl/prd_tap_chain.sv
module prd_tap_chain #(
  parameter int CHAIN_W = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       ref_pulse,
  input  logic [3:0] rate_sel,
  input  logic       slow_base,
  output logic       tick_next
);
  import prd_pkg::*;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] mask;
  logic [3:0]         sel_exp;

  assign sel_exp = tap_exp(rate_sel, slow_base);

  for (genvar i = 0; i < CHAIN_W; i++) begin : g_mask
    assign mask[i] = (32'(sel_exp) > i);
  end

  assign tick_next = ref_pulse && (rate_sel != 4'd0) && ((chain_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      chain_q <= '0;
    else if (ref_pulse)
      chain_q <= chain_q + 1'b1;
  end

endmodule

// File: rtl/prd_sqw_gen.sv
module prd_sqw_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic toggle,
  input  logic en,
  output logic sqw
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear)
      level_q <= 1'b0;
    else if (toggle)
      level_q <= ~level_q;
  end

  assign sqw = en & level_q;

endmodule

// File: rtl/periodic_rate_div.sv
module periodic_rate_div #(
  parameter int PRE_FAST = 128,
  parameter int PRE_MID  = 32,
  parameter int CHAIN_W  = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tb_en,
  input  logic [3:0] rate_sel,
  input  logic [2:0] div_sel,
  input  logic       sqw_en,
  output logic       tick,
  output logic       sqw_out
);
  import prd_pkg::*;

  localparam int CFG_W = 7;

  logic [CFG_W-1:0] cfg_q;
  logic             restart;
  base_mode_e       mode;
  logic             run, hold, chain_clr;
  logic             ref_pulse, tick_next, tick_d, tick_q;

  assign restart   = ({div_sel, rate_sel} != cfg_q);
  assign mode      = base_mode(div_sel);
  assign run       = (mode == BASE_RUN);
  assign hold      = (mode == BASE_HOLD);
  assign chain_clr = restart | hold;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= {div_sel, rate_sel};
  end

  prd_prescaler #(.PRE_FAST(PRE_FAST), .PRE_MID(PRE_MID)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(chain_clr), .run(run),
    .tb_en(tb_en), .div_sel(div_sel), .ref_pulse(ref_pulse)
  );

  prd_tap_chain #(.CHAIN_W(CHAIN_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .clr(chain_clr), .ref_pulse(ref_pulse),
    .rate_sel(rate_sel), .slow_base(div_sel == DIV_SLOW), .tick_next(tick_next)
  );

  assign tick_d = tick_next & ~chain_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick_d;
  end

  assign tick = tick_q;

  prd_sqw_gen u_sqw (
    .clk(clk), .rst_n(rst_n), .clear(hold | (rate_sel == 4'd0)),
    .toggle(tick_d), .en(sqw_en), .sqw(sqw_out)
  );

endmodule

// File: rtl/prd_checker.sv
module prd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tb_en,
  input logic [3:0] rate_sel,
  input logic [2:0] div_sel,
  input logic       sqw_en,
  input logic       tick,
  input logic       sqw_out
);
  assert_rate_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 4'd0) |=> !tick);

  assert_hold_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel[2:1] == 2'b11) |=> (!tick && !sqw_out));

  assert_freeze_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel == 3'b011 || div_sel == 3'b100 || div_sel == 3'b101) |=> !tick);

  assert_tb_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tb_en |=> !tick);

  assert_restart_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ({div_sel, rate_sel} != $past({div_sel, rate_sel})) |=> !tick);

  assert_sqw_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sqw_en && $past(sqw_en) && $rose(sqw_out)) |-> tick);

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

bind periodic_rate_div prd_checker u_prd_checker (
  .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .rate_sel(rate_sel),
  .div_sel(div_sel), .sqw_en(sqw_en), .tick(tick), .sqw_out(sqw_out)
);

// File: tb/test_periodic_rate_div.sv
`timescale 1ns/1ps
module test_periodic_rate_div;
  localparam int PF = 128;
  localparam int PM = 32;

  logic clk = 1'b0, rst_n = 1'b0, tb_en = 1'b1, sqw_en = 1'b1;
  logic [3:0] rate_sel = 4'd0;
  logic [2:0] div_sel = 3'b010;
  logic tick, sqw_out;

  periodic_rate_div i_periodic_rate_div (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .rate_sel(rate_sel),
    .div_sel(div_sel), .sqw_en(sqw_en), .tick(tick), .sqw_out(sqw_out)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit exp_lvl = 1'b0, finished = 1'b0, prev_tick = 1'b0;
  string ctx = "R1";
  int q_cyc[$];
  bit q_lvl[$];
  string q_tag[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int period(input logic [2:0] d, input logic [3:0] r);
    int ratio, e;
    ratio = (d == 3'b000) ? PF : (d == 3'b001) ? PM : 1;
    if (r == 4'd1)      e = (d == 3'b010) ? 7 : 0;
    else if (r == 4'd2) e = (d == 3'b010) ? 8 : 1;
    else                e = int'(r) - 1;
    return ratio << e;
  endfunction

  // Driver: caller is just past a falling edge; change is sampled at next rising edge.
  task automatic run_cfg(input logic [2:0] d, input logic [3:0] r, input int k,
                         input string tag);
    int n, p;
    ctx = tag;
    div_sel = d;
    rate_sel = r;
    n = cyc + 1;
    p = period(d, r);
    for (int i = 1; i <= k; i++) begin
      exp_lvl = ~exp_lvl;
      q_cyc.push_back(n + i * p);
      q_lvl.push_back(exp_lvl & sqw_en);
      q_tag.push_back(tag);
    end
    while (cyc < n + k * p) @(negedge clk);
    #1;
    check(q_cyc.size() == 0, tag, "missing ticks", q_cyc.size(), 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // Monitor: compares observed ticks with the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (tick && prev_tick)
        check(1'b0, "R10", "tick high two cycles", 2, 1);
      if (tick) begin
        if (q_cyc.size() == 0) begin
          check(1'b0, ctx, "unexpected tick (R8)", 1, 0);
        end else begin
          check(cyc == q_cyc[0], q_tag[0], "tick cycle", cyc, q_cyc[0]);
          check(sqw_out == q_lvl[0], q_tag[0], "sqw level R9", int'(sqw_out), int'(q_lvl[0]));
          void'(q_cyc.pop_front());
          void'(q_lvl.pop_front());
          void'(q_tag.pop_front());
        end
      end
      prev_tick = tick;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(tick == 1'b0, "R1", "tick in reset", int'(tick), 0);
    check(sqw_out == 1'b0, "R1", "sqw_out in reset", int'(sqw_out), 0);
    #1 rst_n = 1'b1;
    idle(3);
    // R2 / R8 on the slow base
    run_cfg(3'b010, 4'd3, 4, "R2");
    run_cfg(3'b010, 4'd6, 3, "R8");
    // R3 base-dependent codes
    run_cfg(3'b010, 4'd1, 2, "R3");
    run_cfg(3'b010, 4'd2, 2, "R3");
    run_cfg(3'b000, 4'd1, 2, "R3");
    run_cfg(3'b001, 4'd2, 2, "R3");
    run_cfg(3'b000, 4'd4, 2, "R2");
    run_cfg(3'b010, 4'd15, 2, "R2");
    // R4 rate code zero
    ctx = "R4"; rate_sel = 4'd0; exp_lvl = 1'b0;
    idle(300);
    check(sqw_out == 1'b0, "R4", "sqw_out with rate 0", int'(sqw_out), 0);
    // R5 hold in reset
    run_cfg(3'b010, 4'd5, 1, "R8");
    ctx = "R5"; div_sel = 3'b110; exp_lvl = 1'b0;
    idle(200);
    check(sqw_out == 1'b0, "R5", "sqw_out in hold", int'(sqw_out), 0);
    // R6 freeze keeps level
    run_cfg(3'b010, 4'd5, 3, "R6");
    ctx = "R6"; div_sel = 3'b011;
    idle(150);
    check(sqw_out == 1'b1, "R6", "sqw_out frozen", int'(sqw_out), 1);
    // R7 time-base enable gating
    run_cfg(3'b010, 4'd3, 1, "R7");
    ctx = "R7"; tb_en = 1'b0;
    idle(100);
    check(tick == 1'b0, "R7", "tick with tb_en low", int'(tick), 0);
    tb_en = 1'b1;
    run_cfg(3'b010, 4'd4, 2, "R7");
    // R9 output gating
    sqw_en = 1'b0;
    run_cfg(3'b010, 4'd3, 1, "R9");
    check(sqw_out == 1'b0, "R9", "sqw_out gated", int'(sqw_out), 0);
    sqw_en = 1'b1;
    #1;
    check(sqw_out == exp_lvl, "R9", "sqw_out ungated", int'(sqw_out), int'(exp_lvl));
    idle(2);
    finished = 1'b1;
    check(q_cyc.size() == 0, "R8", "queue drained", q_cyc.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule